// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block gives a host a two-address window onto a bank of configuration registers. The lower address (index port) holds a register number. The upper address (data port) reads or writes the register that the index port names. Access is closed out of reset. It opens only when the opening key byte 0x87 goes to the index port twice running. The byte 0xAA sent to the index port closes access again. While access is closed, the index port only watches for keys.

Registers below 0x30 are shared by all devices. They hold a device-select byte at 0x07 and read-only identity bytes at 0x20 to 0x24. Registers from 0x30 upward are banked: the low bits of the device-select byte pick which logical device's copy is read or written. Each device has an enable bit, a 16-bit base address and a window of function registers. Each device's enable bit and base address drive output pins. Every accepted write to a banked register is also replayed to downstream logic as a one-cycle strobe carrying the device number, the register index and the data byte.

The host port is synchronous. A read returns its byte on `host_rdata` one clock after `host_rd` is sampled. `host_addr` = 0 selects the index port and 1 selects the data port.

Top module: `cfgp_port`

## Requirements
- R1: After reset access is closed, reads of either port return 0xFF, and every `ld_enable` and `ld_base` bit is 0.
- R2: Two index-port writes of 0x87 in a row open access; after only one of them, access stays closed.
- R3: An index-port write of any other byte between the two 0x87 writes restarts the key sequence, so a further pair of 0x87 writes is needed.
- R4: While access is open, an index-port write of 0xAA closes it. While access is closed, data-port writes change no register and raise no strobe, and data-port reads return 0xFF.
- R5: Register 0x07 stores the full written byte and reads it back; its low LD_W bits (3 by default) select the logical device that the banked registers address.
- R6: Registers 0x20/0x21 return the device ID (high byte at 0x20), 0x22 the revision and 0x23/0x24 the vendor ID 0x1934 (high byte at 0x23); writes to them have no effect.
- R7: Per device, bit 0 of register 0x30 is an enable that drives `ld_enable[device]` (its other bits read 0), and 0x60/0x61 hold the high/low base-address bytes that drive `ld_base[16*device +: 16]`; a write under one device leaves every other device unchanged.
- R8: Per device, FN_REGS read/write function registers occupy indices FN_BASE to FN_BASE+FN_REGS-1 (0xF0 to 0xFF by default).
- R9: Each open data-port write to an index of 0x30 or more raises `cfg_wr_stb` for exactly the following cycle with the selected device, the index and the byte; writes below 0x30 raise no strobe.
- R10: `host_rdata` changes only on the clock edge that samples `host_rd`; indices that hold no register read 0x00.
- R11: While access is open, an index-port read returns the current index. The index changes only on open index-port writes other than 0xAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_addr | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after the read |
| cfg_wr_stb | output | 1 | One-cycle strobe for a banked register write |
| cfg_ld | output | LD_W | Logical device of the strobed write |
| cfg_idx | output | 8 | Register index of the strobed write |
| cfg_wdata | output | 8 | Byte of the strobed write |
| ld_enable | output | NUM_LD | Enable bit of each logical device |
| ld_base | output | 16*NUM_LD | Base address of each logical device |

## Verification
The bench attacks the key sequence. It sends a lone 0x87, a 0x87 pair broken by another byte, and 0xAA followed by data-port writes. A design that counted key bytes non-consecutively would open on the broken pair, and a leaky lock would let a write change an enable pin. Bank isolation is checked by writing under one device and reading every other device. The bench also tests select bytes whose upper bits are set, which a design that decoded all eight bits would route to a missing device. The read-only identity bytes and unimplemented indices are written and read back, and every banked write is matched to its strobe.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_OPEN_BYTE  = 8'h87;
    localparam logic [7:0] KEY_CLOSE_BYTE = 8'hAA;

    localparam logic [7:0] IDX_LDSEL      = 8'h07;
    localparam logic [7:0] IDX_DEVID_HI   = 8'h20;
    localparam logic [7:0] IDX_DEVID_LO   = 8'h21;
    localparam logic [7:0] IDX_REVISION   = 8'h22;
    localparam logic [7:0] IDX_VENDOR_HI  = 8'h23;
    localparam logic [7:0] IDX_VENDOR_LO  = 8'h24;
    localparam logic [7:0] IDX_BANK_FIRST = 8'h30;
    localparam logic [7:0] IDX_ENABLE     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI    = 8'h60;
    localparam logic [7:0] IDX_BASE_LO    = 8'h61;

    localparam logic [7:0] LOCKED_READ    = 8'hFF;
    localparam logic [7:0] EMPTY_READ     = 8'h00;

endpackage

// File: rtl/cfgp_key_seq.sv
module cfgp_key_seq
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wbyte,
    output logic       open
);

    typedef struct packed {
        key_state_e st;
    } key_regs_t;

    key_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (idx_wr) begin
            case (r_q.st)
                KEY_LOCKED: if (wbyte == KEY_OPEN_BYTE) r_d.st = KEY_HALF;
                KEY_HALF:   r_d.st = (wbyte == KEY_OPEN_BYTE) ? KEY_OPEN : KEY_LOCKED;
                KEY_OPEN:   if (wbyte == KEY_CLOSE_BYTE) r_d.st = KEY_LOCKED;
                default:    r_d.st = KEY_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: KEY_LOCKED};
        else        r_q <= r_d;
    end

    assign open = (r_q.st == KEY_OPEN);

endmodule

// File: rtl/cfgp_global_regs.sv
module cfgp_global_regs
    import cfgp_pkg::*;
#(
    parameter int          LD_W      = 3,
    parameter logic [15:0] DEV_ID    = 16'h5A3C,
    parameter logic [7:0]  REV_ID    = 8'h11,
    parameter logic [15:0] VENDOR_ID = 16'h1934
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      idx,
    input  logic [7:0]      wbyte,
    output logic [LD_W-1:0] ld_sel,
    output logic [7:0]      rd_data
);

    typedef struct packed {
        logic [7:0] ldsel;
    } glob_regs_t;

    glob_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en && idx == IDX_LDSEL) r_d.ldsel = wbyte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{ldsel: 8'h00};
        else        r_q <= r_d;
    end

    always_comb begin
        case (idx)
            IDX_LDSEL:     rd_data = r_q.ldsel;
            IDX_DEVID_HI:  rd_data = DEV_ID[15:8];
            IDX_DEVID_LO:  rd_data = DEV_ID[7:0];
            IDX_REVISION:  rd_data = REV_ID;
            IDX_VENDOR_HI: rd_data = VENDOR_ID[15:8];
            IDX_VENDOR_LO: rd_data = VENDOR_ID[7:0];
            default:       rd_data = EMPTY_READ;
        endcase
    end

    assign ld_sel = r_q.ldsel[LD_W-1:0];

endmodule

// File: rtl/cfgp_bank_regs.sv
module cfgp_bank_regs
    import cfgp_pkg::*;
#(
    parameter int         NUM_LD  = 8,
    parameter int         LD_W    = 3,
    parameter logic [7:0] FN_BASE = 8'hF0,
    parameter int         FN_REGS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LD_W-1:0]    ld_sel,
    input  logic [7:0]         idx,
    input  logic [7:0]         wbyte,
    output logic [7:0]         rd_data,
    output logic [NUM_LD-1:0]  ld_enable,
    output logic [NUM_LD*16-1:0] ld_base
);

    localparam int BASE_W = 16;

    typedef struct packed {
        logic                     en;
        logic [7:0]               bhi;
        logic [7:0]               blo;
        logic [FN_REGS-1:0][7:0]  fn;
    } bank_t;

    logic [NUM_LD-1:0][7:0] lane_rd;

    for (genvar g = 0; g < NUM_LD; g++) begin : g_ld
        bank_t b_d, b_q;
        logic  hit;

        assign hit = wr_en && (ld_sel == LD_W'(g));

        always_comb begin
            b_d = b_q;
            if (hit) begin
                if (idx == IDX_ENABLE)  b_d.en  = wbyte[0];
                if (idx == IDX_BASE_HI) b_d.bhi = wbyte;
                if (idx == IDX_BASE_LO) b_d.blo = wbyte;
                for (int k = 0; k < FN_REGS; k++) begin
                    if (idx == 8'(int'(FN_BASE) + k)) b_d.fn[k] = wbyte;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) b_q <= '0;
            else        b_q <= b_d;
        end

        always_comb begin
            lane_rd[g] = EMPTY_READ;
            if (idx == IDX_ENABLE)  lane_rd[g] = {7'b0, b_q.en};
            if (idx == IDX_BASE_HI) lane_rd[g] = b_q.bhi;
            if (idx == IDX_BASE_LO) lane_rd[g] = b_q.blo;
            for (int k = 0; k < FN_REGS; k++) begin
                if (idx == 8'(int'(FN_BASE) + k)) lane_rd[g] = b_q.fn[k];
            end
        end

        assign ld_enable[g]                 = b_q.en;
        assign ld_base[g*BASE_W +: BASE_W]  = {b_q.bhi, b_q.blo};
    end

    always_comb begin
        rd_data = EMPTY_READ;
        for (int g = 0; g < NUM_LD; g++) begin
            if (ld_sel == LD_W'(g)) rd_data = lane_rd[g];
        end
    end

endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int          NUM_LD    = 8,
    parameter int          LD_W      = (NUM_LD > 1) ? $clog2(NUM_LD) : 1,
    parameter logic [7:0]  FN_BASE   = 8'hF0,
    parameter int          FN_REGS   = 16,
    parameter logic [15:0] DEV_ID    = 16'h5A3C,
    parameter logic [7:0]  REV_ID    = 8'h11,
    parameter logic [15:0] VENDOR_ID = 16'h1934
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic                 host_addr,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    output logic                 cfg_wr_stb,
    output logic [LD_W-1:0]      cfg_ld,
    output logic [7:0]           cfg_idx,
    output logic [7:0]           cfg_wdata,
    output logic [NUM_LD-1:0]    ld_enable,
    output logic [NUM_LD*16-1:0] ld_base
);

    typedef struct packed {
        logic [7:0]      idx;
        logic [7:0]      rdata;
        logic            stb;
        logic [LD_W-1:0] stb_ld;
        logic [7:0]      stb_idx;
        logic [7:0]      stb_wdata;
    } port_regs_t;

    port_regs_t r_d, r_q;

    logic            key_open;
    logic            idx_wr;
    logic            dat_wr;
    logic            glob_wr;
    logic            bank_wr;
    logic [LD_W-1:0] ld_sel;
    logic [7:0]      glob_rd;
    logic [7:0]      bank_rd;
    logic [7:0]      cur_idx;

    assign cur_idx = r_q.idx;
    assign idx_wr  = host_wr && !host_addr;
    assign dat_wr  = host_wr && host_addr && key_open;
    assign glob_wr = dat_wr && (r_q.idx <  IDX_BANK_FIRST);
    assign bank_wr = dat_wr && (r_q.idx >= IDX_BANK_FIRST);

    cfgp_key_seq u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .wbyte  (host_wdata),
        .open   (key_open)
    );

    cfgp_global_regs #(
        .LD_W      (LD_W),
        .DEV_ID    (DEV_ID),
        .REV_ID    (REV_ID),
        .VENDOR_ID (VENDOR_ID)
    ) u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (glob_wr),
        .idx     (r_q.idx),
        .wbyte   (host_wdata),
        .ld_sel  (ld_sel),
        .rd_data (glob_rd)
    );

    cfgp_bank_regs #(
        .NUM_LD  (NUM_LD),
        .LD_W    (LD_W),
        .FN_BASE (FN_BASE),
        .FN_REGS (FN_REGS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bank_wr),
        .ld_sel    (ld_sel),
        .idx       (r_q.idx),
        .wbyte     (host_wdata),
        .rd_data   (bank_rd),
        .ld_enable (ld_enable),
        .ld_base   (ld_base)
    );

    always_comb begin
        r_d     = r_q;
        r_d.stb = 1'b0;

        if (idx_wr && key_open && host_wdata != KEY_CLOSE_BYTE) r_d.idx = host_wdata;

        if (host_rd) begin
            if (!key_open)                     r_d.rdata = LOCKED_READ;
            else if (!host_addr)               r_d.rdata = r_q.idx;
            else if (r_q.idx < IDX_BANK_FIRST) r_d.rdata = glob_rd;
            else                               r_d.rdata = bank_rd;
        end

        if (bank_wr) begin
            r_d.stb       = 1'b1;
            r_d.stb_ld    = ld_sel;
            r_d.stb_idx   = r_q.idx;
            r_d.stb_wdata = host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.rdata <= LOCKED_READ;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_rdata = r_q.rdata;
    assign cfg_wr_stb = r_q.stb;
    assign cfg_ld     = r_q.stb_ld;
    assign cfg_idx    = r_q.stb_idx;
    assign cfg_wdata  = r_q.stb_wdata;

endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk #(
    parameter int NUM_LD = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic              host_addr,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic              unlocked,
    input logic [7:0]        idx_q,
    input logic              cfg_wr_stb,
    input logic [NUM_LD-1:0] ld_enable
);

    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !unlocked) |=> (host_rdata == 8'hFF)); // R4

    AST_LOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr && !unlocked) |=> !cfg_wr_stb); // R4

    AST_LOCKED_ENABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(ld_enable)); // R4

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(host_wr && !host_addr && host_wdata == 8'h87)); // R2

    AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && host_wr && !host_addr && host_wdata == 8'hAA) |=> !unlocked); // R4

    AST_BANK_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && host_wr && host_addr && idx_q >= 8'h30) |=> cfg_wr_stb); // R9

    AST_GLOBAL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr && idx_q < 8'h30) |=> !cfg_wr_stb); // R9

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata)); // R10

endmodule

bind cfgp_port cfgp_port_chk #(.NUM_LD(NUM_LD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .unlocked   (key_open),
    .idx_q      (cur_idx),
    .cfg_wr_stb (cfg_wr_stb),
    .ld_enable  (ld_enable)
);

// File: tb/cfgp_port_test.sv
module cfgp_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int NLD  = 8;
    localparam int NFN  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_addr = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        cfg_wr_stb;
    logic [2:0]  cfg_ld;
    logic [7:0]  cfg_idx;
    logic [7:0]  cfg_wdata;
    logic [NLD-1:0]    ld_enable;
    logic [NLD*16-1:0] ld_base;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic       s_stb;
    logic [2:0] s_ld;
    logic [7:0] s_idx;
    logic [7:0] s_data;

    // reference model
    logic [7:0] m_ldsel;
    logic       m_en  [NLD];
    logic [7:0] m_bhi [NLD];
    logic [7:0] m_blo [NLD];
    logic [7:0] m_fn  [NLD][NFN];

    cfgp_port uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cfg_wr_stb(cfg_wr_stb), .cfg_ld(cfg_ld), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .ld_enable(ld_enable), .ld_base(ld_base)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        s_stb = cfg_wr_stb; s_ld = cfg_ld; s_idx = cfg_idx; s_data = cfg_wdata;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(posedge clk); #1;
        d = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] i, output logic [7:0] d);
        wr(1'b0, i);
        rd(1'b1, d);
    endtask

    task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
        wr(1'b0, i);
        wr(1'b1, d);
    endtask

    function automatic logic [7:0] exp_bank(input int ld, input logic [7:0] i);
        if (i == 8'h30) return {7'b0, m_en[ld]};
        if (i == 8'h60) return m_bhi[ld];
        if (i == 8'h61) return m_blo[ld];
        if (i >= 8'hF0) return m_fn[ld][i - 8'hF0];
        return 8'h00;
    endfunction

    function automatic logic [NLD-1:0] exp_enables();
        logic [NLD-1:0] v;
        for (int g = 0; g < NLD; g++) v[g] = m_en[g];
        return v;
    endfunction

    function automatic logic [7:0] pick_bank_idx();
        case ($urandom % 5)
            0: return 8'h30;
            1: return 8'h60;
            2: return 8'h61;
            3: return 8'hF0 + 8'($urandom % NFN);
            default: return 8'h31 + 8'($urandom % 8'h2F);
        endcase
    endfunction

    task automatic model_write(input logic [7:0] i, input logic [7:0] d);
        int ld = int'(m_ldsel[2:0]);
        if (i == 8'h30) m_en[ld] = d[0];
        else if (i == 8'h60) m_bhi[ld] = d;
        else if (i == 8'h61) m_blo[ld] = d;
        else if (i >= 8'hF0) m_fn[ld][i - 8'hF0] = d;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h00C0FFEE));
        m_ldsel = 8'h00;
        for (int g = 0; g < NLD; g++) begin
            m_en[g] = 1'b0; m_bhi[g] = 8'h00; m_blo[g] = 8'h00;
            for (int k = 0; k < NFN; k++) m_fn[g][k] = 8'h00;
        end

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        check(host_rdata == 8'hFF, "R1 rdata at reset", host_rdata, 8'hFF);
        rd(1'b1, d); check(d == 8'hFF, "R1 data port locked", d, 8'hFF);
        rd(1'b0, d); check(d == 8'hFF, "R1 index port locked", d, 8'hFF);
        check(ld_enable == '0, "R1 enables clear", ld_enable, 0);
        check(ld_base == '0, "R1 bases clear", 32'(ld_base), 0);

        // R2 a single key is not enough
        wr(1'b0, 8'h87);
        rd(1'b1, d); check(d == 8'hFF, "R2 one key stays locked", d, 8'hFF);
        wr(1'b0, 8'h87);
        rd(1'b0, d); check(d == 8'h00, "R2 open after two keys, R11 index kept", d, 8'h00);

        // R4 close, then R3 broken pair
        wr(1'b0, 8'hAA);
        rd(1'b0, d); check(d == 8'hFF, "R4 closed by AA", d, 8'hFF);
        wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
        rd(1'b1, d); check(d == 8'hFF, "R3 broken sequence stays locked", d, 8'hFF);
        wr(1'b0, 8'h87);
        rd(1'b0, d); check(d == 8'h00, "R3 fresh pair opens", d, 8'h00);

        // R6 identity, read-only
        rd_reg(8'h20, d); check(d == 8'h5A, "R6 device id high", d, 8'h5A);
        rd_reg(8'h21, d); check(d == 8'h3C, "R6 device id low", d, 8'h3C);
        rd_reg(8'h22, d); check(d == 8'h11, "R6 revision", d, 8'h11);
        rd_reg(8'h23, d); check(d == 8'h19, "R6 vendor high", d, 8'h19);
        rd_reg(8'h24, d); check(d == 8'h34, "R6 vendor low", d, 8'h34);
        wr_reg(8'h20, 8'h00);
        check(s_stb == 1'b0, "R9 no strobe below 0x30", s_stb, 0);
        rd(1'b1, d); check(d == 8'h5A, "R6 write ignored", d, 8'h5A);
        rd(1'b0, d); check(d == 8'h20, "R11 index readback", d, 8'h20);

        // R10 empty indices
        rd_reg(8'h10, d); check(d == 8'h00, "R10 empty global index", d, 8'h00);
        rd_reg(8'h40, d); check(d == 8'h00, "R10 empty banked index", d, 8'h00);

        // R5 device select with upper bits set
        wr_reg(8'h07, 8'hFA); m_ldsel = 8'hFA;
        rd(1'b1, d); check(d == 8'hFA, "R5 select readback", d, 8'hFA);
        wr_reg(8'h30, 8'hFF); model_write(8'h30, 8'hFF);
        check(s_stb && s_ld == 3'd2 && s_idx == 8'h30 && s_data == 8'hFF,
              "R9 strobe payload", {s_stb, s_ld, s_idx, s_data}, {1'b1, 3'd2, 8'h30, 8'hFF});
        rd(1'b1, d); check(d == 8'h01, "R7 enable reads bit 0", d, 8'h01);
        check(ld_enable == 8'h04, "R5 R7 enable of device 2", ld_enable, 8'h04);
        wr_reg(8'h60, 8'hAB); model_write(8'h60, 8'hAB);
        wr_reg(8'h61, 8'hCD); model_write(8'h61, 8'hCD);
        check(ld_base[2*16 +: 16] == 16'hABCD, "R7 base pins", ld_base[2*16 +: 16], 16'hABCD);
        wr_reg(8'hFF, 8'h5E); model_write(8'hFF, 8'h5E);
        rd(1'b1, d); check(d == 8'h5E, "R8 last function register", d, 8'h5E);
        wr_reg(8'h07, 8'h05); m_ldsel = 8'h05;
        rd_reg(8'h30, d); check(d == 8'h00, "R7 other device isolated", d, 8'h00);
        rd_reg(8'hFF, d); check(d == 8'h00, "R8 other device isolated", d, 8'h00);

        // R4 locked writes ignored
        wr_reg(8'h07, 8'h02); m_ldsel = 8'h02;
        wr(1'b0, 8'h30);
        wr(1'b0, 8'hAA);
        wr(1'b1, 8'h00);
        check(s_stb == 1'b0, "R4 no strobe while locked", s_stb, 0);
        check(ld_enable == 8'h04, "R4 enable unchanged while locked", ld_enable, 8'h04);
        wr(1'b0, 8'h60);
        rd(1'b1, d); check(d == 8'hFF, "R4 locked read", d, 8'hFF);
        wr(1'b0, 8'h87); wr(1'b0, 8'h87);
        rd(1'b0, d); check(d == 8'h30, "R11 locked index write ignored", d, 8'h30);
        rd(1'b1, d); check(d == 8'h01, "R4 register kept", d, 8'h01);

        // random traffic against the model
        for (int n = 0; n < 600; n++) begin
            int op = int'($urandom % 4);
            if (op == 0) begin
                logic [7:0] s = 8'($urandom);
                wr_reg(8'h07, s); m_ldsel = s;
            end else if (op == 1) begin
                logic [7:0] i = pick_bank_idx();
                logic [7:0] v = 8'($urandom);
                wr_reg(i, v); model_write(i, v);
                check(s_stb && s_ld == m_ldsel[2:0] && s_idx == i && s_data == v,
                      "R9 random strobe", {s_stb, s_ld, s_idx, s_data},
                      {1'b1, m_ldsel[2:0], i, v});
                check(ld_enable == exp_enables(), "R7 random enables", ld_enable, exp_enables());
            end else begin
                logic [7:0] i = pick_bank_idx();
                rd_reg(i, d);
                check(d == exp_bank(int'(m_ldsel[2:0]), i), "R8 random readback",
                      d, exp_bank(int'(m_ldsel[2:0]), i));
            end
        end
        for (int g = 0; g < NLD; g++) begin
            check(ld_base[g*16 +: 16] == {m_bhi[g], m_blo[g]}, "R7 final base",
                  ld_base[g*16 +: 16], {m_bhi[g], m_blo[g]});
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule